// File: doc/BRIEF.md
# DMA Windowed Bus-Time Limiter

This block caps how long one DMA channel may hold the system bus. Time runs in fixed windows of `WINDOW_LEN` clocks, one right after the other. Within each window the channel may own the bus for at most `BUDGET` clocks. The block counts the clocks the channel actually owns the bus in the current window. It raises permission while budget remains and drops it once the budget is used up.

Higher-priority masters and interrupts can preempt the channel. Its use of the bus may then be split into several shorter bursts inside one window. Clocks lost to waiting or preemption are not charged. They are also not paid back: every window starts with exactly `BUDGET` clocks, and whatever was left of the previous window is discarded.

Top module: `dmal_limiter`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), the window position is 0, the used count is 0, and `budget_left_o` equals `BUDGET`.
- R2: A window lasts exactly `WINDOW_LEN` clocks. After the last cycle of a window (position `WINDOW_LEN-1`), position 0 of the next window follows at once.
- R3: `budget_left_o` never exceeds `BUDGET`. The used count saturates at `BUDGET` and never exceeds it.
- R4: `grant_o` is high exactly when `dma_req_i` is high, `preempt_i` is low, and `budget_left_o` is nonzero. All three are taken in the same cycle.
- R5: A cycle with `bus_owned_i` high, at a window position other than the last, lowers `budget_left_o` by one at the next edge, unless the budget is already 0. A cycle with `bus_owned_i` low leaves the budget unchanged, whatever the values of `dma_req_i` and `preempt_i`.
- R6: Once the budget reaches 0, `grant_o` stays low from the next cycle until the window wraps.
- R7: At the window boundary the budget returns to `BUDGET`, even in the middle of a burst. Ownership during the last cycle of a window is not charged to either window. Budget left unused is not carried over.
- R8: Preemption splits use of the bus into bursts. Cycles in which `preempt_i` holds grant low and the bus is not owned are not charged. The cycles that are charged across all bursts add up to at most `BUDGET` per window.
- R9: A reset asserted in the middle of a window restarts the window count from 0 and refills the budget.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dma_req_i | input | 1 | The channel requests the bus |
| bus_owned_i | input | 1 | The channel owns the bus in this cycle |
| preempt_i | input | 1 | A higher-priority master or an interrupt is active |
| grant_o | output | 1 | Permission for the channel to use the bus |
| budget_left_o | output | $clog2(BUDGET+1) | Clocks of budget left in the current window |

## Verification
The bench builds the block with `WINDOW_LEN=16` and `BUDGET=4`. With these values a budget runs out within a few cycles, and a window boundary comes every sixteen clocks. The bench can therefore cover, in a short run, several wraps, exhaustion in the middle of a window, saturation under forced ownership, a burst that spans a boundary, and preemption patterns. It checks every cycle against a counter model that follows the requirements.

// File: rtl/dmal_pkg.sv
package dmal_pkg;
    localparam int unsigned DEF_WINDOW_LEN = 1024;
    localparam int unsigned DEF_BUDGET     = 128;
endpackage

// File: rtl/dmal_window.sv
module dmal_window #(
    parameter int unsigned WINDOW_LEN = dmal_pkg::DEF_WINDOW_LEN
) (
    input  logic clk,
    input  logic rst_n,
    output logic last_o
);
    localparam int unsigned WW = (WINDOW_LEN > 1) ? $clog2(WINDOW_LEN) : 1;
    localparam logic [WW-1:0] LAST = WW'(WINDOW_LEN - 1);

    typedef struct packed {
        logic [WW-1:0] pos;
    } win_st_t;

    win_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.pos == LAST) st_d.pos = '0;
        else                  st_d.pos = st_q.pos + WW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign last_o = (st_q.pos == LAST);

    // R2: the position wraps to zero right after the last cycle
    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> (st_q.pos == '0));
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !last_o |=> (st_q.pos == $past(st_q.pos) + WW'(1)));
endmodule

// File: rtl/dmal_budget.sv
module dmal_budget #(
    parameter int unsigned BUDGET = dmal_pkg::DEF_BUDGET
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        win_last_i,
    input  logic                        owned_i,
    output logic [$clog2(BUDGET+1)-1:0] used_o,
    output logic                        spent_o
);
    localparam int unsigned UW = $clog2(BUDGET + 1);
    localparam logic [UW-1:0] CAP = UW'(BUDGET);

    typedef struct packed {
        logic [UW-1:0] used;
    } bud_st_t;

    bud_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (win_last_i)                        st_d.used = '0;
        else if (owned_i && (st_q.used < CAP)) st_d.used = st_q.used + UW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign used_o  = st_q.used;
    assign spent_o = (st_q.used == CAP);

    // R3: the used count never passes the cap
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.used <= CAP);
    // R5: cycles without ownership are free
    p_idle_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!owned_i && !win_last_i) |=> $stable(st_q.used));
    // R5: an owned cycle costs one clock while budget remains
    p_charge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (owned_i && !win_last_i && !spent_o) |=> (st_q.used == $past(st_q.used) + UW'(1)));
    // R7: the boundary clears the count
    p_refill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        win_last_i |=> (st_q.used == '0));
endmodule

// File: rtl/dmal_limiter.sv
module dmal_limiter #(
    parameter int unsigned WINDOW_LEN = dmal_pkg::DEF_WINDOW_LEN,
    parameter int unsigned BUDGET     = dmal_pkg::DEF_BUDGET
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        dma_req_i,
    input  logic                        bus_owned_i,
    input  logic                        preempt_i,
    output logic                        grant_o,
    output logic [$clog2(BUDGET+1)-1:0] budget_left_o
);
    localparam int unsigned UW = $clog2(BUDGET + 1);

    logic          win_last;
    logic [UW-1:0] used;
    logic          spent;

    dmal_window #(.WINDOW_LEN(WINDOW_LEN)) u_window (
        .clk    (clk),
        .rst_n  (rst_n),
        .last_o (win_last)
    );

    dmal_budget #(.BUDGET(BUDGET)) u_budget (
        .clk        (clk),
        .rst_n      (rst_n),
        .win_last_i (win_last),
        .owned_i    (bus_owned_i),
        .used_o     (used),
        .spent_o    (spent)
    );

    assign grant_o       = dma_req_i && !preempt_i && !spent;
    assign budget_left_o = UW'(BUDGET) - used;

    // R6: no permission while the budget is spent
    p_spent_no_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (budget_left_o == '0) |-> !grant_o);
    // R3: the remaining budget is never above the cap
    p_left_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        budget_left_o <= UW'(BUDGET));
    // R4: preemption always withdraws permission
    p_preempt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        preempt_i |-> !grant_o);
endmodule

// File: tb/test_dmal_limiter.sv
module test_dmal_limiter;
    localparam int unsigned WL = 16;
    localparam int unsigned BG = 4;
    localparam int unsigned UW = $clog2(BG + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, own = 1'b0, pre = 1'b0;
    logic grant;
    logic [UW-1:0] left;

    int n_tests = 0, n_fail = 0;
    int m_pos = 0, m_used = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dmal_limiter #(.WINDOW_LEN(WL), .BUDGET(BG)) i_dmal_limiter (
        .clk(clk), .rst_n(rst_n), .dma_req_i(req), .bus_owned_i(own),
        .preempt_i(pre), .grant_o(grant), .budget_left_o(left)
    );

    // One cycle: drive at negedge, check, advance the model at posedge.
    task automatic step(input logic r, input logic p, input int own_mode,
                        input logic rs, input string tag);
        logic exp_g;
        @(negedge clk);
        rst_n = rs; req = r; pre = p;
        exp_g = r && !p && (m_used < BG);
        case (own_mode)
            0: own = 1'b0;
            1: own = 1'b1;
            default: own = exp_g;
        endcase
        #1;
        n_tests++;
        if (grant !== exp_g) begin
            n_fail++;
            $display("FAIL %s grant: actual %0b expected %0b (pos %0d)", tag, grant, exp_g, m_pos);
        end
        n_tests++;
        if (left !== UW'(BG - m_used)) begin
            n_fail++;
            $display("FAIL %s budget_left: actual %0d expected %0d (pos %0d)", tag, left, BG - m_used, m_pos);
        end
        @(posedge clk);
        if (!rs) begin
            m_pos = 0; m_used = 0;
        end else if (m_pos == WL - 1) begin
            m_pos = 0; m_used = 0;
        end else begin
            m_pos++;
            if (own && m_used < BG) m_used++;
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        // R1: reset state
        step(1'b0, 1'b0, 0, 1'b0, "R1");
        step(1'b0, 1'b0, 0, 1'b0, "R1");
        step(1'b0, 1'b0, 0, 1'b1, "R1");
        // R4 / R6 / R2: continuous use, exhaustion and several wraps
        for (int i = 0; i < 3 * WL; i++) step(1'b1, 1'b0, 2, 1'b1, "R6");
        // R8: preemption breaks the bursts
        for (int i = 0; i < 3 * WL; i++) step(1'b1, (i % 3) == 0, 2, 1'b1, "R8");
        // R5: forced ownership without request, saturation
        for (int i = 0; i < 2 * WL; i++) step(1'b0, 1'b0, 1, 1'b1, "R5");
        // R5: no ownership is never charged
        for (int i = 0; i < WL + 3; i++) step(1'b1, i[0], 0, 1'b1, "R5");
        // R7: burst straddling the boundary
        while (m_pos != WL - 2) step(1'b0, 1'b0, 0, 1'b1, "R7");
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1, 1'b1, "R7");
        // R4: sweep every input combination
        for (int i = 0; i < 2 * WL; i++) step(i[0], i[1], i[2] ? 1 : 0, 1'b1, "R4");
        // R9: reset in the middle of a window
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 2, 1'b1, "R9");
        step(1'b0, 1'b0, 0, 1'b0, "R9");
        for (int i = 0; i < 2 * WL; i++) step(1'b1, 1'b0, 2, 1'b1, "R9");
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule